// File: doc/BRIEF.md
# Nibble-Serial SIMD Element Datapath

This block is the arithmetic core of one element in a SIMD processor array. It has no program counter and no decoder. An array sequencer broadcasts one micro-operation at a time: opcode, operand width, two source register indices, a destination index, an immediate word, and a start strobe. Each element also has its own `active` flag. The element runs integer add, subtract, bitwise logic, copy and load-immediate on 8, 16, 32 or 64-bit operands. It works through a 4-bit ALU one nibble per clock, least significant nibble first, and writes each result nibble back into its local register file.

The register file has 40 registers of 32 bits. Its storage is nibble-granular, so narrow operations touch only the low byte or half-word of the destination. A 64-bit operand uses an adjacent register pair. Every element steps for the same number of cycles whether it is active or not, so the whole array finishes in lockstep. `done` pulses when the last nibble is written, and the carry and zero flags are published at that point. Every written nibble also appears on a small result stream, which lets a register be observed by copying it.

Top module: `pe_nibble_datapath`

## Requirements
- R1: A command accepted at clock edge E0 (`start` high, `busy` low) with width code w (0=8, 1=16, 2=32, 3=64 bits) writes its nibbles at edges E1..En, where n = 2<<w. `done` is high for exactly one cycle, after En.
- R2: With opcode 0 (ADD) the result is A+B mod 2^N. With opcode 1 (SUB) it is A-B mod 2^N. The carry passes from nibble to nibble, least significant first.
- R3: Opcodes 2 (AND), 3 (OR), 4 (XOR) and 5 (NOT A) act bitwise. Opcode 6 (PASS) copies A. Opcode 7 (LDI) writes the low N bits of `imm`.
- R4: After an active command, `flag_c` is the carry out of the top nibble for ADD. For SUB it is 1 exactly when A >= B unsigned. For every other opcode it is 0.
- R5: After an active command, `flag_z` is 1 exactly when all N result bits are zero.
- R6: `flag_c` and `flag_z` change only at the end of an active command. They hold their values between commands.
- R7: A command narrower than 32 bits leaves the upper nibbles of its destination register unchanged.
- R8: A 64-bit operand occupies register r (low word) and register r+1 (high word). The carry crosses from the low word into the high word.
- R9: A command with `active` low at its start writes no register and leaves the flags unchanged. Its `done` still arrives after the same number of cycles.
- R10: A `start` that arrives while `busy` is high is ignored.
- R11: For an active command, `res_vld` pulses once per nibble, least significant first, with `res_nib` carrying the value written. An inactive command produces no pulses.
- R12: While reset is held and just after it is released, `done`, `busy`, `res_vld`, `flag_c` and `flag_z` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Broadcast command strobe |
| op | input | 3 | Opcode (see R2, R3) |
| width | input | 2 | Operand width code |
| src_a | input | 6 | First source register index |
| src_b | input | 6 | Second source register index |
| dst | input | 6 | Destination register index |
| imm | input | 64 | Broadcast immediate for LDI |
| active | input | 1 | Element enable, sampled with start |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| res_vld | output | 1 | A result nibble was written |
| res_nib | output | 4 | Written result nibble |
| flag_c | output | 1 | Final carry / no-borrow flag |
| flag_z | output | 1 | Final zero flag |

## Verification
The bench targets the carry chain at several boundaries. These include a carry rippling out of a full byte, a word, and all 64 bits, and one crossing from the low register of a pair into the high one. A design that dropped the nibble carry, or that reset it at a word boundary, would return wrong sums there. Subtraction cases with and without a borrow check that the first nibble gets a carry-in of one and that the flag means "no borrow"; an inverted flag would fail them. A byte-wide write into a prefilled register exposes a design that clears upper nibbles. An inactive command, and a second strobe issued in the middle of a command, expose a design that still writes, touches the flags, or restarts its step count.

// File: rtl/pe_pkg.sv
package pe_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_NOT  = 3'd5,
    OP_PASS = 3'd6,
    OP_LDI  = 3'd7
  } pe_op_e;

  typedef enum logic [1:0] {
    W_8  = 2'd0,
    W_16 = 2'd1,
    W_32 = 2'd2,
    W_64 = 2'd3
  } pe_width_e;

  function automatic logic op_is_arith(input pe_op_e o);
    return (o == OP_ADD) || (o == OP_SUB);
  endfunction

endpackage

// File: rtl/pe_nib_alu.sv
// One nibble step of the element ALU: arithmetic with carry in/out, bitwise logic.
module pe_nib_alu
  import pe_pkg::*;
#(
  parameter int NW = 4
) (
  input  pe_op_e          op,
  input  logic [NW-1:0]   a,
  input  logic [NW-1:0]   b,
  input  logic [NW-1:0]   imm,
  input  logic            cin,
  output logic [NW-1:0]   y,
  output logic            cout
);

  logic [NW:0] sum;

  always_comb begin
    sum  = '0;
    y    = '0;
    cout = 1'b0;
    unique case (op)
      OP_ADD: begin
        sum  = {1'b0, a} + {1'b0, b} + {{NW{1'b0}}, cin};
        y    = sum[NW-1:0];
        cout = sum[NW];
      end
      OP_SUB: begin
        // A - B = A + ~B + 1; the +1 enters as carry-in of the first nibble
        sum  = {1'b0, a} + {1'b0, ~b} + {{NW{1'b0}}, cin};
        y    = sum[NW-1:0];
        cout = sum[NW];
      end
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      OP_PASS: y = a;
      OP_LDI:  y = imm;
      default: y = a;
    endcase
  end

endmodule

// File: rtl/pe_nib_rf.sv
// Nibble-granular register storage. One write port; each read port gets its
// own copy of the array so every copy maps onto a simple dual-port block RAM.
module pe_nib_rf #(
  parameter int NREG = 40,
  parameter int NPW  = 8,
  parameter int NW   = 4,
  parameter int AW   = 9
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [NW-1:0]   wdata,
  input  logic            re,
  input  logic [AW-1:0]   raddr_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [NW-1:0]   rdata_a,
  output logic [NW-1:0]   rdata_b
);

  localparam int         DEPTH   = NREG * NPW;
  localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);
  localparam int         NPORT   = 2;

  logic [NPORT-1:0][AW-1:0] raddr_v;
  logic [NPORT-1:0][NW-1:0] rdata_v;

  assign raddr_v[0] = raddr_a;
  assign raddr_v[1] = raddr_b;
  assign rdata_a    = rdata_v[0];
  assign rdata_b    = rdata_v[1];

  for (genvar p = 0; p < NPORT; p++) begin : g_copy
    logic [NW-1:0] mem [DEPTH];
    logic [NW-1:0] rq;

    always_ff @(posedge clk) begin
      if (we && ({1'b0, waddr} < DEPTH_L))
        mem[waddr] <= wdata;
      if (re)
        rq <= ({1'b0, raddr_v[p]} < DEPTH_L) ? mem[raddr_v[p]] : '0;
    end

    assign rdata_v[p] = rq;
  end

endmodule

// File: rtl/pe_step_seq.sv
// Step sequencer: accepts a command, counts nibble steps, pulses done.
module pe_step_seq
  import pe_pkg::*;
#(
  parameter int NW = 4,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  pe_width_e     width,
  input  logic          active,
  output logic          launch,
  output logic          busy,
  output logic          is_last,
  output logic [IW-1:0] idx,
  output logic          act_q,
  output logic          done
);

  localparam int BASE_NIBS = 8 / NW;

  logic [IW-1:0] last_q;
  logic [IW:0]   n_nibs;

  always_comb begin
    n_nibs = (IW+1)'(BASE_NIBS) << width;
  end

  assign launch  = start & ~busy;
  assign is_last = busy & (idx == last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      idx    <= '0;
      last_q <= '0;
      act_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        busy   <= 1'b1;
        idx    <= '0;
        last_q <= IW'(n_nibs - 1'b1);
        act_q  <= active;
      end else if (busy) begin
        if (idx == last_q) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pe_nibble_datapath.sv
// SIMD element datapath: broadcast micro-op executed one nibble per clock.
module pe_nibble_datapath
  import pe_pkg::*;
#(
  parameter int NREG   = 40,
  parameter int WORD_W = 32,
  parameter int MAX_W  = 64,
  parameter int NW     = 4,
  parameter int RIW    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [1:0]        width,
  input  logic [RIW-1:0]    src_a,
  input  logic [RIW-1:0]    src_b,
  input  logic [RIW-1:0]    dst,
  input  logic [MAX_W-1:0]  imm,
  input  logic              active,
  output logic              busy,
  output logic              done,
  output logic              res_vld,
  output logic [NW-1:0]     res_nib,
  output logic              flag_c,
  output logic              flag_z
);

  localparam int NPW    = WORD_W / NW;
  localparam int NPW_LG = $clog2(NPW);
  localparam int IW     = $clog2(MAX_W / NW);
  localparam int AW     = RIW + NPW_LG;

  // command latch
  pe_op_e           op_q;
  logic [RIW-1:0]   ra_q, rb_q, rd_q;
  logic [MAX_W-1:0] imm_q;

  // sequencer
  logic          launch, busy_w, last_w, act_q;
  logic [IW-1:0] idx;

  // datapath
  logic [AW-1:0] raddr_a, raddr_b, waddr;
  logic          rd_en, wr_en;
  logic [NW-1:0] rdata_a, rdata_b, imm_nib, alu_y;
  logic          alu_cin, alu_cout, c_run, z_run, z_in, z_out;

  function automatic logic [AW-1:0] nib_addr(input logic [RIW-1:0] base,
                                             input logic [IW-1:0]  i);
    logic [RIW-1:0] r;
    r = base;
    if (i[IW-1])
      r = (base == RIW'(NREG - 1)) ? '0 : base + 1'b1;
    return {r, i[NPW_LG-1:0]};
  endfunction

  pe_step_seq #(.NW(NW), .IW(IW)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .width   (pe_width_e'(width)),
    .active  (active),
    .launch  (launch),
    .busy    (busy_w),
    .is_last (last_w),
    .idx     (idx),
    .act_q   (act_q),
    .done    (done)
  );

  assign busy = busy_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= OP_ADD;
      ra_q  <= '0;
      rb_q  <= '0;
      rd_q  <= '0;
      imm_q <= '0;
    end else if (launch) begin
      op_q  <= pe_op_e'(op);
      ra_q  <= src_a;
      rb_q  <= src_b;
      rd_q  <= dst;
      imm_q <= imm;
    end
  end

  // Read address: nibble 0 straight from the broadcast fields on launch,
  // otherwise the nibble after the one being written.
  always_comb begin
    if (launch) begin
      raddr_a = nib_addr(src_a, '0);
      raddr_b = nib_addr(src_b, '0);
    end else begin
      raddr_a = nib_addr(ra_q, idx + 1'b1);
      raddr_b = nib_addr(rb_q, idx + 1'b1);
    end
  end

  assign rd_en = launch | (busy_w & ~last_w);
  assign wr_en = busy_w & act_q;
  assign waddr = nib_addr(rd_q, idx);

  pe_nib_rf #(.NREG(NREG), .NPW(NPW), .NW(NW), .AW(AW)) u_rf (
    .clk     (clk),
    .we      (wr_en),
    .waddr   (waddr),
    .wdata   (alu_y),
    .re      (rd_en),
    .raddr_a (raddr_a),
    .raddr_b (raddr_b),
    .rdata_a (rdata_a),
    .rdata_b (rdata_b)
  );

  assign imm_nib = imm_q[idx*NW +: NW];
  assign alu_cin = (idx == '0) ? (op_q == OP_SUB) : c_run;
  assign z_in    = (idx == '0) ? 1'b1 : z_run;

  pe_nib_alu #(.NW(NW)) u_alu (
    .op   (op_q),
    .a    (rdata_a),
    .b    (rdata_b),
    .imm  (imm_nib),
    .cin  (alu_cin),
    .y    (alu_y),
    .cout (alu_cout)
  );

  assign z_out = z_in & (alu_y == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      c_run   <= 1'b0;
      z_run   <= 1'b1;
      res_vld <= 1'b0;
      res_nib <= '0;
      flag_c  <= 1'b0;
      flag_z  <= 1'b0;
    end else begin
      res_vld <= wr_en;
      if (busy_w) begin
        c_run   <= alu_cout;
        z_run   <= z_out;
        res_nib <= alu_y;
        if (last_w && act_q) begin
          flag_c <= op_is_arith(op_q) ? alu_cout : 1'b0;
          flag_z <= z_out;
        end
      end
    end
  end

endmodule

// File: rtl/pe_nibble_datapath_chk.sv
module pe_nibble_datapath_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [1:0] width,
  input logic       busy,
  input logic       is_last,
  input logic       done,
  input logic       we,
  input logic       act_q,
  input logic [2:0] op_q,
  input logic       flag_c,
  input logic       flag_z,
  input logic       res_vld
);

  logic [4:0] cnt, exp_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      exp_n <= '0;
    end else if (start && !busy) begin
      cnt   <= '0;
      exp_n <= 5'd2 << width;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R1
  done_count_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cnt == exp_n));

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  inactive_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !act_q) |-> !we);

  // R6
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(flag_c) && $stable(flag_z)));

  // R4
  logic_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (done && act_q && (op_q > 3'd1)) |-> !flag_c);

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !is_last) |=> (busy && $stable(op_q)));

  // R11
  stream_src_chk: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> ($past(busy) && $past(act_q)));

endmodule

bind pe_nibble_datapath pe_nibble_datapath_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .width   (width),
  .busy    (busy_w),
  .is_last (last_w),
  .done    (done),
  .we      (wr_en),
  .act_q   (act_q),
  .op_q    (op_q),
  .flag_c  (flag_c),
  .flag_z  (flag_z),
  .res_vld (res_vld)
);

// File: tb/pe_nibble_datapath_test.sv
`timescale 1ns/1ps
module pe_nibble_datapath_test;
  import pe_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [1:0]  width = 2'd0;
  logic [5:0]  src_a = '0, src_b = '0, dst = '0;
  logic [63:0] imm = '0;
  logic        active = 1'b1;
  logic        busy, done, res_vld, flag_c, flag_z;
  logic [3:0]  res_nib;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pe_nibble_datapath uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .width(width),
    .src_a(src_a), .src_b(src_b), .dst(dst), .imm(imm), .active(active),
    .busy(busy), .done(done), .res_vld(res_vld), .res_nib(res_nib),
    .flag_c(flag_c), .flag_z(flag_z)
  );

  typedef struct packed {
    logic [2:0]  o;
    logic [1:0]  w;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] y;
    logic        c;
    logic        z;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{OP_ADD,  W_8,  64'h3C, 64'h05, 64'h41, 1'b0, 1'b0},
    '{OP_ADD,  W_8,  64'hFF, 64'h01, 64'h00, 1'b1, 1'b1},
    '{OP_SUB,  W_16, 64'h1234, 64'h0234, 64'h1000, 1'b1, 1'b0},
    '{OP_SUB,  W_16, 64'h0001, 64'h0002, 64'hFFFF, 1'b0, 1'b0},
    '{OP_ADD,  W_32, 64'hFFFF_FFFF, 64'h1, 64'h0, 1'b1, 1'b1},
    '{OP_ADD,  W_64, 64'h0000_0000_FFFF_FFFF, 64'h1, 64'h0000_0001_0000_0000, 1'b0, 1'b0},
    '{OP_SUB,  W_64, 64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0},
    '{OP_SUB,  W_32, 64'h5, 64'h5, 64'h0, 1'b1, 1'b1},
    '{OP_AND,  W_32, 64'hF0F0_F0F0, 64'h0FF0_0FF0, 64'h00F0_00F0, 1'b0, 1'b0},
    '{OP_OR,   W_16, 64'h1200, 64'h0034, 64'h1234, 1'b0, 1'b0},
    '{OP_XOR,  W_64, 64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA, 64'h0, 1'b0, 1'b1},
    '{OP_NOT,  W_8,  64'h5A, 64'h0, 64'hA5, 1'b0, 1'b0},
    '{OP_PASS, W_32, 64'hDEAD_BEEF, 64'h0, 64'hDEAD_BEEF, 1'b0, 1'b0},
    '{OP_LDI,  W_16, 64'hBEEF, 64'h0, 64'hBEEF, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic [1:0] w,
                        input logic [5:0] ra, input logic [5:0] rb, input logic [5:0] rd,
                        input logic [63:0] im, input logic act,
                        output logic [63:0] res, output int nc, output int nv);
    int n;
    int k;
    @(negedge clk);
    start = 1'b1; op = o; width = w; src_a = ra; src_b = rb; dst = rd;
    imm = im; active = act;
    @(negedge clk);
    start = 1'b0; active = 1'b1;
    n = 1; k = 0; res = '0;
    while (!done && n < 40) begin
      if (res_vld) begin
        if (k < 16) res[k*4 +: 4] = res_nib;
        k++;
      end
      @(negedge clk);
      n++;
    end
    if (res_vld) begin
      if (k < 16) res[k*4 +: 4] = res_nib;
      k++;
    end
    nc = (n < 40) ? n - 1 : -1;
    nv = k;
  endtask

  task automatic load(input logic [5:0] rd, input logic [63:0] v);
    logic [63:0] r;
    int nc, nv;
    run_op(OP_LDI, W_64, 6'd0, 6'd0, rd, v, 1'b1, r, nc, nv);
  endtask

  task automatic peek32(input logic [5:0] ra, output logic [63:0] r);
    int nc, nv;
    run_op(OP_PASS, W_32, ra, 6'd0, 6'd0, 64'h0, 1'b1, r, nc, nv);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1: watchdog expired, actual=hung expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    logic [63:0] r;
    int nc, nv, n, ndone;
    logic c0, z0;

    // R12 reset state
    repeat (5) @(negedge clk);
    chk("R12 reset outputs", {59'b0, busy, done, res_vld, flag_c, flag_z}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 after release", {59'b0, busy, done, res_vld, flag_c, flag_z}, 64'h0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      load(6'd2, VECS[i].a);
      load(6'd4, VECS[i].b);
      run_op(VECS[i].o, VECS[i].w, 6'd2, 6'd4, 6'd8, VECS[i].a, 1'b1, r, nc, nv);
      if (VECS[i].o <= 3'd1) chk("R2 arith result (R8 for pairs)", r, VECS[i].y);
      else                   chk("R3 logic result", r, VECS[i].y);
      chk("R1 step count", 64'(nc), 64'(2 << VECS[i].w));
      chk("R11 stream pulses", 64'(nv), 64'(2 << VECS[i].w));
      chk("R4 carry flag", {63'b0, flag_c}, {63'b0, VECS[i].c});
      chk("R5 zero flag", {63'b0, flag_z}, {63'b0, VECS[i].z});
    end

    // R6 flags hold while idle
    c0 = flag_c; z0 = flag_z;
    repeat (6) @(negedge clk);
    chk("R6 flags idle", {62'b0, flag_c, flag_z}, {62'b0, c0, z0});

    // R7 byte write keeps upper nibbles
    load(6'd2, 64'h3C);
    load(6'd4, 64'h05);
    load(6'd10, 64'hCAFE_BABE);
    run_op(OP_ADD, W_8, 6'd2, 6'd4, 6'd10, 64'h0, 1'b1, r, nc, nv);
    peek32(6'd10, r);
    chk("R7 partial write", r, 64'hCAFE_BA41);

    // R8 register pair layout
    load(6'd20, 64'h0123_4567_89AB_CDEF);
    peek32(6'd20, r);
    chk("R8 low word at base", r, 64'h89AB_CDEF);
    peek32(6'd21, r);
    chk("R8 high word at base+1", r, 64'h0123_4567);

    // R9 inactive element
    load(6'd14, 64'h1111_1111);
    load(6'd15, 64'h0);
    c0 = flag_c; z0 = flag_z;
    run_op(OP_ADD, W_32, 6'd2, 6'd4, 6'd14, 64'h0, 1'b0, r, nc, nv);
    chk("R9 inactive step count", 64'(nc), 64'd8);
    chk("R9 inactive flags", {62'b0, flag_c, flag_z}, {62'b0, c0, z0});
    chk("R11 inactive no stream", 64'(nv), 64'd0);
    peek32(6'd14, r);
    chk("R9 inactive no write", r, 64'h1111_1111);

    // R10 start while busy ignored
    load(6'd16, 64'h0);
    load(6'd17, 64'h1234_5678);
    @(negedge clk);
    start = 1'b1; op = OP_ADD; width = W_32; src_a = 6'd2; src_b = 6'd4;
    dst = 6'd16; active = 1'b1;
    @(negedge clk);
    start = 1'b0; n = 1;
    @(negedge clk);
    n++;
    start = 1'b1; op = OP_LDI; width = W_8; dst = 6'd17; imm = 64'hAB;
    @(negedge clk);
    n++;
    start = 1'b0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk("R10 original timing kept", 64'(n - 1), 64'd8);
    ndone = 0;
    repeat (12) begin
      @(negedge clk);
      if (done) ndone++;
    end
    chk("R10 no second command", 64'(ndone), 64'd0);
    peek32(6'd16, r);
    chk("R10 first command result", r, 64'h41);
    peek32(6'd17, r);
    chk("R10 second command not run", r, 64'h1234_5678);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule